// File: doc/BRIEF.md
# Message-Object Transmit Queue Controller

This block keeps the bookkeeping for a circular transmit queue of fixed-size message objects. The objects themselves sit in an external message RAM. Software writes an object at the byte address the block presents. It then writes the control word with the increment bit set, which moves the head (user) pointer on by one object. Software starts transmission by setting a sticky transmit request in the same control word.

A transmit engine takes objects from the tail (FIFO index). It may fetch only while the block raises `fetch_ok`. It reports each finished object with a one-cycle `tx_done`. From the occupancy the block derives three status flags: empty, half-empty and not-full. Hardware drops the transmit request when the queue drains.

The block handles pointer wrap-around and address generation. It also protects against overfill, ignoring an increment while the queue is full and flagging it.

Top module: `mo_txq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its idle state. In that state both pointers are 0, occupancy is 0, `user_addr` is 0x200, `tx_req` and `inc_overflow` are 0, and `q_empty`, `q_half_empty` and `q_not_full` are all 1.
- R2: A clock edge with `ctrl_we` high and `ctrl_wdata[8]` high, while the queue is not full, advances `head_idx` by one. `user_addr` then equals 0x200 + 0x18 × `head_idx`; object 1 is at 0x218. With `ctrl_we` low, `ctrl_wdata` has no effect.
- R3: Both `head_idx` and `tail_idx` wrap from DEPTH−1 (4) back to 0.
- R4: `q_empty` is 1 exactly when occupancy is 0. It clears after the first accepted increment and sets again once every queued object has been sent.
- R5: `q_half_empty` is 1 exactly when occupancy ≤ DEPTH/2 (2 for depth 5). With 3 objects queued it reads 0.
- R6: `q_not_full` is 0 exactly when occupancy equals DEPTH; at that point all three flags read 0.
- R7: An increment while the queue is full changes neither pointer nor occupancy. It raises `inc_overflow` for exactly the following cycle.
- R8: `tx_req` is set by a control write with `ctrl_wdata[3]` high, and writing 0 there does not clear it. Hardware clears it on the accepted `tx_done` that leaves the queue empty. If a set and that clear fall on the same edge, the set wins.
- R9: `fetch_ok` is 1 exactly when `tx_req` is 1 and the queue is not empty. A `tx_done` while `fetch_ok` is 0 is ignored.
- R10: Each accepted `tx_done` advances `tail_idx` by one and lowers occupancy by one.
- R11: An accepted increment and an accepted `tx_done` on the same edge advance both pointers and leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: bit 8 increment head, bit 3 set transmit request |
| tx_done | input | 1 | Transmit engine finished the object at the tail |
| head_idx | output | 5 | User (head) object index |
| tail_idx | output | 5 | FIFO (tail) object index |
| user_addr | output | 16 | RAM byte address of the next object to load |
| occupancy | output | 3 | Number of queued objects |
| q_empty | output | 1 | Queue empty flag |
| q_half_empty | output | 1 | Occupancy at most half the depth |
| q_not_full | output | 1 | Queue not full |
| tx_req | output | 1 | Sticky transmit request |
| fetch_ok | output | 1 | Engine may fetch the object at the tail |
| inc_overflow | output | 1 | One-cycle pulse after an increment refused while full |

## Verification
Loading by software and draining by the engine can land on the same edge. Two cases matter most: a simultaneous increment and completion, and a transmit-request set that meets the completion emptying the queue. The bench provokes both in directed steps. It also provokes them many times under seeded random traffic in which the increment, the request set and `tx_done` are drawn independently. After every edge, a bench model built from the requirements supplies the expected pointers, occupancy, flags and request state, and each output is compared against it.

// File: rtl/mo_txq_pkg.sv
// Package: shared constants and types for the message-object transmit queue.
// Assumes a 16-bit control word; bit 8 requests a head increment and bit 3
// sets the transmit request.
package mo_txq_pkg;

    localparam int CTRL_W     = 16;
    localparam int BIT_INC    = 8;
    localparam int BIT_TXSET  = 3;

    // Per-edge events decided by the occupancy tracker
    typedef struct packed {
        logic inc_ok;   // increment accepted
        logic done_ok;  // completion accepted
        logic refused;  // increment refused because full
        logic drain;    // accepted completion leaves the queue empty
    } q_event_t;

    // Width of a pointer into a queue of the given depth
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/mo_txq_wrap_ptr.sv
// Module: circular object pointer.
// Advances by one on each enabled edge and wraps from DEPTH-1 to 0.
// Assumes DEPTH >= 1. A power-of-two depth uses natural roll-over; any
// other depth uses an explicit compare.
module mo_txq_wrap_ptr #(
    parameter int DEPTH = 5,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0) && (DEPTH > 1)
                          && ((1 << PTR_W) == DEPTH);

    logic [PTR_W-1:0] nxt;

    generate
        if (POW2) begin : g_roll
            // next value rolls over naturally at the power-of-two boundary
            always_comb nxt = ptr + PTR_W'(1);
        end else begin : g_cmp
            // next value returns to zero after the last slot
            always_comb nxt = (ptr == LAST) ? '0 : ptr + PTR_W'(1);
        end
    endgenerate

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= nxt;
    end
endmodule

// File: rtl/mo_txq_occupancy.sv
// Module: occupancy counter and status flags.
// Decides which requests are accepted this edge, keeps the object count,
// derives empty / half-empty / not-full, and registers the overflow pulse.
// Assumes the transmit request input is the registered request state.
module mo_txq_occupancy
    import mo_txq_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_req,
    input  logic             done_req,
    input  logic             txreq,
    output q_event_t         ev,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             half_empty,
    output logic             not_full,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    // status flags from the current count
    always_comb begin
        empty      = (count == '0);
        half_empty = (count <= HALF_CNT);
        not_full   = (count != FULL_CNT);
    end

    // acceptance of this edge's requests
    always_comb begin
        ev.inc_ok  = inc_req && not_full;
        ev.refused = inc_req && !not_full;
        ev.done_ok = done_req && txreq && !empty;
        ev.drain   = ev.done_ok && !ev.inc_ok && (count == ONE);
    end

    // object count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (ev.inc_ok && !ev.done_ok)
            count <= count + ONE;
        else if (ev.done_ok && !ev.inc_ok)
            count <= count - ONE;
    end

    // one-cycle overflow indication
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= ev.refused;
    end
endmodule

// File: rtl/mo_txq_txreq.sv
// Module: sticky transmit request.
// Set only by software; cleared by hardware when the queue drains. A set
// on the same edge as the drain wins.
module mo_txq_txreq (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic hw_drain,
    output logic req
);
    // request state
    always_ff @(posedge clk) begin
        if (!rst_n)        req <= 1'b0;
        else if (sw_set)   req <= 1'b1;
        else if (hw_drain) req <= 1'b0;
    end
endmodule

// File: rtl/mo_txq_addr.sv
// Module: object byte-address generator.
// Computes BASE + index * STRIDE combinationally. Assumes the result fits
// in ADDR_W bits for every index below DEPTH.
module mo_txq_addr #(
    parameter int BASE   = 32'h200,
    parameter int STRIDE = 32'h18,
    parameter int PTR_W  = 3,
    parameter int ADDR_W = 16
) (
    input  logic [PTR_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam bit STRIDE_POW2 = (STRIDE > 0) && ((STRIDE & (STRIDE - 1)) == 0);

    generate
        if (STRIDE_POW2) begin : g_shift
            localparam int SH = $clog2(STRIDE);
            // power-of-two stride: shift instead of multiply
            always_comb addr = ADDR_W'(BASE) + (ADDR_W'(idx) << SH);
        end else begin : g_mul
            // general stride: constant multiply
            always_comb addr = ADDR_W'(BASE) + ADDR_W'(idx) * ADDR_W'(STRIDE);
        end
    endgenerate
endmodule

// File: rtl/mo_txq_ctrl.sv
// Module: message-object transmit queue controller (top).
// Tracks head/tail pointers of a circular queue of DEPTH objects in an
// external RAM, produces status flags, the sticky transmit request, the
// fetch permission and the byte address of the next object to load.
// Assumes IDX_W >= pointer width and that the engine only asserts tx_done
// for an object it fetched while fetch_ok was high.
module mo_txq_ctrl
    import mo_txq_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 16,
    parameter int BASE   = 32'h200,
    parameter int STRIDE = 32'h18,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tx_done,
    output logic [IDX_W-1:0]  head_idx,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [ADDR_W-1:0] user_addr,
    output logic [CNT_W-1:0]  occupancy,
    output logic              q_empty,
    output logic              q_half_empty,
    output logic              q_not_full,
    output logic              tx_req,
    output logic              fetch_ok,
    output logic              inc_overflow
);
    localparam int PTR_W = ptr_width(DEPTH);

    logic             inc_req;
    logic             set_req;
    q_event_t         ev;
    logic [PTR_W-1:0] head_p;
    logic [PTR_W-1:0] tail_p;

    // decode of the control word write
    always_comb begin
        inc_req = ctrl_we && ctrl_wdata[BIT_INC];
        set_req = ctrl_we && ctrl_wdata[BIT_TXSET];
    end

    mo_txq_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_req    (inc_req),
        .done_req   (tx_done),
        .txreq      (tx_req),
        .ev         (ev),
        .count      (occupancy),
        .empty      (q_empty),
        .half_empty (q_half_empty),
        .not_full   (q_not_full),
        .ovf        (inc_overflow)
    );

    mo_txq_wrap_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_head (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ev.inc_ok),
        .ptr   (head_p)
    );

    mo_txq_wrap_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ev.done_ok),
        .ptr   (tail_p)
    );

    mo_txq_txreq u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_set   (set_req),
        .hw_drain (ev.drain),
        .req      (tx_req)
    );

    mo_txq_addr #(.BASE(BASE), .STRIDE(STRIDE), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_addr (
        .idx  (head_p),
        .addr (user_addr)
    );

    // index fields and fetch permission
    always_comb begin
        head_idx = IDX_W'(head_p);
        tail_idx = IDX_W'(tail_p);
        fetch_ok = tx_req && !q_empty;
    end
endmodule

// File: rtl/mo_txq_ctrl_chk.sv
// Module: assertion checker for mo_txq_ctrl, attached by bind.
// Observes the top-level ports only.
module mo_txq_ctrl_chk #(
    parameter int DEPTH = 5,
    parameter int IDX_W = 5,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_we,
    input logic [15:0]      ctrl_wdata,
    input logic             tx_done,
    input logic [IDX_W-1:0] head_idx,
    input logic [IDX_W-1:0] tail_idx,
    input logic [CNT_W-1:0] occupancy,
    input logic             q_empty,
    input logic             q_half_empty,
    input logic             q_not_full,
    input logic             tx_req,
    input logic             fetch_ok,
    input logic             inc_overflow
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic inc_w;
    logic set_w;
    assign inc_w = ctrl_we && ctrl_wdata[8];
    assign set_w = ctrl_we && ctrl_wdata[3];

    // R4: zero occupancy shows every flag set
    a_r4_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> (q_empty && q_half_empty && q_not_full));

    // R6: full queue clears all flags
    a_r6_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == FULL_CNT) |-> (!q_empty && !q_half_empty && !q_not_full));

    // R2 / R3: accepted increment steps the head with wrap
    a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_w && q_not_full) |=>
        (head_idx == (($past(head_idx) == LAST_IDX) ? '0 : $past(head_idx) + IDX_W'(1))));

    // R7: overflow pulse only after an increment at full
    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        inc_overflow |-> ($past(inc_w) && !$past(q_not_full)));

    // R7: refused increment leaves the head alone
    a_r7_head_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_w && !q_not_full) |=> $stable(head_idx));

    // R8: the request only falls when the queue has emptied
    a_r8_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_req) |-> q_empty);

    // R8: a software set is always seen on the next cycle
    a_r8_req_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> tx_req);

    // R9: fetch needs both request and content
    a_r9_fetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok |-> (tx_req && !q_empty));

    // R9: ignored completion leaves the tail alone
    a_r9_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !fetch_ok) |=> $stable(tail_idx));

    // R11: simultaneous accepted load and completion keep occupancy
    a_r11_both_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_w && q_not_full && tx_done && fetch_ok) |=> $stable(occupancy));
endmodule

bind mo_txq_ctrl mo_txq_ctrl_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .tx_done      (tx_done),
    .head_idx     (head_idx),
    .tail_idx     (tail_idx),
    .occupancy    (occupancy),
    .q_empty      (q_empty),
    .q_half_empty (q_half_empty),
    .q_not_full   (q_not_full),
    .tx_req       (tx_req),
    .fetch_ok     (fetch_ok),
    .inc_overflow (inc_overflow)
);

// File: tb/tb_mo_txq_ctrl.sv
`timescale 1ns/1ps
module tb_mo_txq_ctrl;
    localparam int D = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        tx_done = 1'b0;
    logic [4:0]  head_idx, tail_idx;
    logic [15:0] user_addr;
    logic [2:0]  occupancy;
    logic        q_empty, q_half_empty, q_not_full, tx_req, fetch_ok, inc_overflow;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    // bench model state
    int  m_head, m_tail, m_cnt;
    bit  m_req, m_ovf;

    always #2.5 clk = ~clk;

    mo_txq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_done(tx_done), .head_idx(head_idx), .tail_idx(tail_idx),
        .user_addr(user_addr), .occupancy(occupancy), .q_empty(q_empty),
        .q_half_empty(q_half_empty), .q_not_full(q_not_full), .tx_req(tx_req),
        .fetch_ok(fetch_ok), .inc_overflow(inc_overflow)
    );

    function automatic int exp_addr(input int idx);
        return 32'h200 + idx * 32'h18;
    endfunction

    function automatic bit exp_half(input int cnt);
        return cnt <= D / 2;
    endfunction

    function automatic int wrap(input int p);
        return (p == D - 1) ? 0 : p + 1;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2/R3 head_idx", int'(head_idx), m_head);
        chk("R10/R3 tail_idx", int'(tail_idx), m_tail);
        chk("R2 user_addr", int'(user_addr), exp_addr(m_head));
        chk("R11 occupancy", int'(occupancy), m_cnt);
        chk("R4 q_empty", int'(q_empty), int'(m_cnt == 0));
        chk("R5 q_half_empty", int'(q_half_empty), int'(exp_half(m_cnt)));
        chk("R6 q_not_full", int'(q_not_full), int'(m_cnt != D));
        chk("R8 tx_req", int'(tx_req), int'(m_req));
        chk("R9 fetch_ok", int'(fetch_ok), int'(m_req && m_cnt > 0));
        chk("R7 inc_overflow", int'(inc_overflow), int'(m_ovf));
    endtask

    // one edge: drive at negedge, update model, compare at following negedge
    task automatic step(input bit we, input logic [15:0] wd, input bit dn);
        bit inc, set, inc_ok, done_ok;
        ctrl_we = we; ctrl_wdata = wd; tx_done = dn;
        inc = we && wd[8];
        set = we && wd[3];
        inc_ok  = inc && (m_cnt < D);
        done_ok = dn && m_req && (m_cnt > 0);
        @(posedge clk);
        m_ovf = inc && (m_cnt == D);
        if (set) m_req = 1'b1;
        else if (done_ok && !inc_ok && m_cnt == 1) m_req = 1'b0;
        if (inc_ok) m_head = wrap(m_head);
        if (done_ok) m_tail = wrap(m_tail);
        m_cnt = m_cnt + int'(inc_ok) - int'(done_ok);
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_wdata = '0; tx_done = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_head = 0; m_tail = 0; m_cnt = 0; m_req = 0; m_ovf = 0;
        compare_all();   // R1 reset state
        chk("R1 user_addr 0x200", int'(user_addr), 32'h200);
    endtask

    localparam logic [15:0] W_INC = 16'h0100;
    localparam logic [15:0] W_SET = 16'h0008;

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        // directed: load one, request, send it
        step(1, W_INC, 0);
        chk("R2 addr of object 1", int'(user_addr), 32'h218);
        step(1, W_SET, 0);
        step(0, 16'h0000, 1);
        chk("R8 request cleared on drain", int'(tx_req), 0);
        chk("R4 empty after drain", int'(q_empty), 1);
        // load three: half-empty must clear
        for (int i = 0; i < 3; i++) step(1, W_INC, 0);
        chk("R5 half clear at 3", int'(q_half_empty), 0);
        // load two more: full, head wraps to 1
        for (int i = 0; i < 2; i++) step(1, W_INC, 0);
        chk("R3 head wrapped to 1", int'(head_idx), 1);
        chk("R6 flags all clear when full",
            int'({q_empty, q_half_empty, q_not_full}), 0);
        // increment while full is refused
        step(1, W_INC, 0);
        chk("R7 overflow pulse", int'(inc_overflow), 1);
        step(0, 16'h0000, 0);
        chk("R7 overflow one cycle", int'(inc_overflow), 0);
        // ignored completion without request
        step(0, 16'h0000, 1);
        chk("R9 done ignored tail", int'(tail_idx), 1);
        // write with strobe low is ignored
        step(0, 16'hFFFF, 0);
        chk("R2 strobe low ignored", int'(occupancy), 5);
        // request and drain all five
        step(1, W_SET, 0);
        for (int i = 0; i < 5; i++) step(0, 16'h0000, 1);
        chk("R10 tail back at 1", int'(tail_idx), 1);
        chk("R8 request cleared", int'(tx_req), 0);
        // simultaneous load and completion
        step(1, W_INC, 0);
        step(1, W_INC | W_SET, 0);
        step(1, W_INC, 1);
        chk("R11 occupancy unchanged", int'(occupancy), 2);
        // set meets drain: set wins
        step(0, 16'h0000, 1);
        step(1, W_SET, 1);
        chk("R8 set wins over drain", int'(tx_req), 1);
        // writing zero to the request bit does not clear it
        step(1, 16'h0000, 0);
        chk("R8 zero write keeps request", int'(tx_req), 1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] wd;
            wd = 16'($urandom);
            wd[8] = ($urandom % 2) == 0;
            wd[3] = ($urandom % 6) == 0;
            step(($urandom % 4) != 0, wd, ($urandom % 2) == 0);
        end

        // reset in mid-run
        step(1, W_INC, 0);
        do_reset();

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule